// File: doc/BRIEF.md
# Test Point Insertion Network

This block wraps chosen internal nodes of a logic block with test points, so that hard-to-reach nodes can be watched and driven from a tester. An observation point samples a node, or the XOR of a group of nodes, into a flip-flop. The observation flip-flops form one serial chain that is unloaded on a single pin. A control point puts a 2:1 multiplexer between a node's source and its destination. In test mode, a flip-flop from a second serial chain drives the destination in place of the source. A combined scan point does both jobs on one node: it samples the source end and can force the destination end.

Two pins set the operating mode. Scan enable chooses between capturing the nodes and shifting both chains. Test mode chooses whether destinations follow their sources or the control flip-flops. The widths are set by parameters: the number of observation points, the group size merged by XOR into each one, the number of control points and the number of combined scan points. Each of these counts must be at least 1.

Top module: `tpi_network`

## Requirements
- R1: While rst_n is low, every observation and control flip-flop is 0. This shows as obs_so = 0, ctl_so = 0, and, with test_mode = 1, all cp_dst and sp_dst bits = 0.
- R2: With test_mode = 0, cp_dst[i] equals cp_src[i] and sp_dst[j] equals sp_src[j] in the same cycle, whatever the value of scan_en. No register lies on that path.
- R3: A rising clock edge with scan_en = 0 loads every observation flip-flop in parallel from its tapped node.
- R4: A rising clock edge with scan_en = 1 moves the observation chain one place toward obs_so. Observation cell 0 takes obs_si, and obs_so is the last observation cell. Cells 0 to NUM_OP-1 are the observation points, and the combined scan points follow them.
- R5: A rising clock edge with scan_en = 1 moves the control chain one place toward ctl_so. Control cell 0 takes ctl_si, and ctl_so is the last control cell. Cells 0 to NUM_CP-1 are the control points, and the combined scan points follow them.
- R6: A rising clock edge with scan_en = 0 leaves every control flip-flop unchanged, so forced values stay steady through capture.
- R7: With test_mode = 1, cp_dst[i] equals control cell i and sp_dst[j] equals control cell NUM_CP+j.
- R8: Observation point k captures the XOR of obs_nodes[k*GRP_W +: GRP_W]. An even number of ones in the group captures 0.
- R9: Combined scan point j captures sp_src[j] into observation cell NUM_OP+j, including while it is forcing sp_dst[j] from its control cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1 = shift both chains, 0 = capture nodes and hold control cells |
| test_mode | input | 1 | 1 = control cells drive the destinations |
| obs_nodes | input | NUM_OP*GRP_W | Low-observability nodes, grouped per observation point |
| cp_src | input | NUM_CP | Source ends of the controlled nodes |
| cp_dst | output | NUM_CP | Destination ends of the controlled nodes |
| sp_src | input | NUM_SP | Source ends of the combined scan point nodes |
| sp_dst | output | NUM_SP | Destination ends of the combined scan point nodes |
| obs_si | input | 1 | Serial input of the observation chain |
| obs_so | output | 1 | Serial output of the observation chain |
| ctl_si | input | 1 | Serial input of the control chain |
| ctl_so | output | 1 | Serial output of the control chain |

## Verification
The bench builds the block with three observation points, each merging two nodes, three control points and two combined scan points. With these values both chains cross the boundary from one kind of cell to the other. Groups with even and odd parity show the XOR merge cancelling and passing. A chain length of five lets an unload tell apart a swapped order, a lost stage or a stuck serial pin. Because the combined scan points sit at the output end of the observation chain, their captures come out first. This lets the bench confirm that the source, not the forced destination, is the value that gets sampled.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

    // Operating mode decoded from the two test pins
    typedef enum logic [1:0] {
        TP_FUNC        = 2'b00,  // destinations follow sources, observe cells capture
        TP_SHIFT       = 2'b01,  // chains shift, destinations follow sources
        TP_FORCE_CAPT  = 2'b10,  // destinations forced, observe cells capture
        TP_FORCE_SHIFT = 2'b11   // destinations forced, chains shift
    } tp_mode_e;

endpackage

// File: rtl/tpi_mode_dec.sv
module tpi_mode_dec
    import tpi_pkg::*;
(
    input  logic scan_en,
    input  logic test_mode,
    output logic obs_shift,
    output logic ctl_shift,
    output logic force_en
);

    tp_mode_e mode;

    always_comb begin
        mode = tp_mode_e'({test_mode, scan_en});
    end

    always_comb begin
        obs_shift = 1'b0;
        ctl_shift = 1'b0;
        force_en  = 1'b0;
        unique case (mode)
            TP_FUNC: begin
                obs_shift = 1'b0;
                ctl_shift = 1'b0;
                force_en  = 1'b0;
            end
            TP_SHIFT: begin
                obs_shift = 1'b1;
                ctl_shift = 1'b1;
                force_en  = 1'b0;
            end
            TP_FORCE_CAPT: begin
                obs_shift = 1'b0;
                ctl_shift = 1'b0;
                force_en  = 1'b1;
            end
            TP_FORCE_SHIFT: begin
                obs_shift = 1'b1;
                ctl_shift = 1'b1;
                force_en  = 1'b1;
            end
            default: begin
                obs_shift = 1'b0;
                ctl_shift = 1'b0;
                force_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tpi_xor_merge.sv
module tpi_xor_merge #(
    parameter int W = 2
) (
    input  logic [W-1:0] nodes,
    output logic         merged
);

    generate
        if (W == 1) begin : g_single
            assign merged = nodes[0];
        end else begin : g_tree
            assign merged = ^nodes;
        end
    endgenerate

endmodule

// File: rtl/tpi_obs_cell.sv
module tpi_obs_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic node,
    input  logic scan_prev,
    output logic q
);

    logic d_sel;

    // input 0 = observed node, input 1 = previous stage
    always_comb begin
        d_sel = shift ? scan_prev : node;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d_sel;
        end
    end

endmodule

// File: rtl/tpi_ctl_cell.sv
module tpi_ctl_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic scan_prev,
    input  logic force_en,
    input  logic src,
    output logic q,
    output logic dst
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (shift) begin
            q <= scan_prev;
        end
    end

    // input 0 = original source, input 1 = control flop
    always_comb begin
        dst = force_en ? q : src;
    end

endmodule

// File: rtl/tpi_network.sv
module tpi_network #(
    parameter int NUM_OP = 3,
    parameter int GRP_W  = 2,
    parameter int NUM_CP = 3,
    parameter int NUM_SP = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic                    test_mode,
    input  logic [NUM_OP*GRP_W-1:0] obs_nodes,
    input  logic [NUM_CP-1:0]       cp_src,
    output logic [NUM_CP-1:0]       cp_dst,
    input  logic [NUM_SP-1:0]       sp_src,
    output logic [NUM_SP-1:0]       sp_dst,
    input  logic                    obs_si,
    output logic                    obs_so,
    input  logic                    ctl_si,
    output logic                    ctl_so
);

    localparam int OBS_LEN = NUM_OP + NUM_SP;
    localparam int CTL_LEN = NUM_CP + NUM_SP;

    logic obs_shift;
    logic ctl_shift;
    logic force_en;

    logic [OBS_LEN-1:0] obs_tap;
    logic [OBS_LEN-1:0] obs_prev;
    logic [OBS_LEN-1:0] obs_chain;

    logic [CTL_LEN-1:0] ctl_src_all;
    logic [CTL_LEN-1:0] ctl_dst_all;
    logic [CTL_LEN-1:0] ctl_prev;
    logic [CTL_LEN-1:0] ctl_chain;

    tpi_mode_dec u_mode (
        .scan_en   (scan_en),
        .test_mode (test_mode),
        .obs_shift (obs_shift),
        .ctl_shift (ctl_shift),
        .force_en  (force_en)
    );

    // node taps: merged groups first, then combined-point sources
    generate
        for (genvar k = 0; k < NUM_OP; k++) begin : g_merge
            tpi_xor_merge #(.W(GRP_W)) u_merge (
                .nodes  (obs_nodes[k*GRP_W +: GRP_W]),
                .merged (obs_tap[k])
            );
        end
        for (genvar j = 0; j < NUM_SP; j++) begin : g_sp_tap
            assign obs_tap[NUM_OP+j] = sp_src[j];
        end
    endgenerate

    // serial links, cell 0 nearest the serial input
    assign obs_prev    = {obs_chain[OBS_LEN-2:0], obs_si};
    assign ctl_prev    = {ctl_chain[CTL_LEN-2:0], ctl_si};
    assign ctl_src_all = {sp_src, cp_src};

    generate
        for (genvar i = 0; i < OBS_LEN; i++) begin : g_obs
            tpi_obs_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .shift     (obs_shift),
                .node      (obs_tap[i]),
                .scan_prev (obs_prev[i]),
                .q         (obs_chain[i])
            );
        end
        for (genvar i = 0; i < CTL_LEN; i++) begin : g_ctl
            tpi_ctl_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .shift     (ctl_shift),
                .scan_prev (ctl_prev[i]),
                .force_en  (force_en),
                .src       (ctl_src_all[i]),
                .q         (ctl_chain[i]),
                .dst       (ctl_dst_all[i])
            );
        end
    endgenerate

    assign cp_dst = ctl_dst_all[NUM_CP-1:0];
    assign sp_dst = ctl_dst_all[CTL_LEN-1:NUM_CP];
    assign obs_so = obs_chain[OBS_LEN-1];
    assign ctl_so = ctl_chain[CTL_LEN-1];

endmodule

// File: rtl/tpi_network_chk.sv
module tpi_network_chk #(
    parameter int NUM_OP = 3,
    parameter int NUM_CP = 3,
    parameter int NUM_SP = 2,
    localparam int OBS_LEN = NUM_OP + NUM_SP,
    localparam int CTL_LEN = NUM_CP + NUM_SP
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scan_en,
    input logic               test_mode,
    input logic               obs_si,
    input logic               ctl_si,
    input logic               obs_so,
    input logic               ctl_so,
    input logic [NUM_CP-1:0]  cp_src,
    input logic [NUM_CP-1:0]  cp_dst,
    input logic [NUM_SP-1:0]  sp_src,
    input logic [NUM_SP-1:0]  sp_dst,
    input logic [OBS_LEN-1:0] obs_chain,
    input logic [CTL_LEN-1:0] ctl_chain
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (obs_chain == '0 && ctl_chain == '0));

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (cp_dst == cp_src && sp_dst == sp_src));

    // R4
    obs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (obs_chain[0] == $past(obs_si)
                     && obs_so == $past(obs_chain[OBS_LEN-2])));

    // R5
    ctl_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (ctl_chain[0] == $past(ctl_si)
                     && ctl_so == $past(ctl_chain[CTL_LEN-2])));

    // R6
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(ctl_chain));

    // R7
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (cp_dst == ctl_chain[NUM_CP-1:0]
                       && sp_dst == ctl_chain[CTL_LEN-1:NUM_CP]));

    // R9
    sp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> obs_chain[OBS_LEN-1:NUM_OP] == $past(sp_src));

endmodule

bind tpi_network tpi_network_chk #(
    .NUM_OP (NUM_OP),
    .NUM_CP (NUM_CP),
    .NUM_SP (NUM_SP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .test_mode (test_mode),
    .obs_si    (obs_si),
    .ctl_si    (ctl_si),
    .obs_so    (obs_so),
    .ctl_so    (ctl_so),
    .cp_src    (cp_src),
    .cp_dst    (cp_dst),
    .sp_src    (sp_src),
    .sp_dst    (sp_dst),
    .obs_chain (obs_chain),
    .ctl_chain (ctl_chain)
);

// File: tb/tb_tpi_network.sv
module tb_tpi_network;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OP  = 3;
    localparam int GRP_W   = 2;
    localparam int NUM_CP  = 3;
    localparam int NUM_SP  = 2;
    localparam int OBS_LEN = NUM_OP + NUM_SP;
    localparam int CTL_LEN = NUM_CP + NUM_SP;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b1;
    logic                    scan_en = 1'b0;
    logic                    test_mode = 1'b0;
    logic [NUM_OP*GRP_W-1:0] obs_nodes = '0;
    logic [NUM_CP-1:0]       cp_src = '0;
    logic [NUM_CP-1:0]       cp_dst;
    logic [NUM_SP-1:0]       sp_src = '0;
    logic [NUM_SP-1:0]       sp_dst;
    logic                    obs_si = 1'b0;
    logic                    obs_so;
    logic                    ctl_si = 1'b0;
    logic                    ctl_so;

    int checks = 0;
    int fails  = 0;

    tpi_network #(
        .NUM_OP (NUM_OP),
        .GRP_W  (GRP_W),
        .NUM_CP (NUM_CP),
        .NUM_SP (NUM_SP)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .test_mode (test_mode),
        .obs_nodes (obs_nodes),
        .cp_src    (cp_src),
        .cp_dst    (cp_dst),
        .sp_src    (sp_src),
        .sp_dst    (sp_dst),
        .obs_si    (obs_si),
        .obs_so    (obs_so),
        .ctl_si    (ctl_si),
        .ctl_so    (ctl_so)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: queue element 0 is the cell nearest the serial input
    bit obs_q[$];
    bit ctl_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_q.delete();
            ctl_q.delete();
            for (int i = 0; i < OBS_LEN; i++) obs_q.push_back(1'b0);
            for (int i = 0; i < CTL_LEN; i++) ctl_q.push_back(1'b0);
        end else if (scan_en) begin
            obs_q.push_front(obs_si);
            void'(obs_q.pop_back());
            ctl_q.push_front(ctl_si);
            void'(ctl_q.pop_back());
        end else begin
            for (int k = 0; k < NUM_OP; k++) begin
                bit p;
                p = 1'b0;
                for (int b = 0; b < GRP_W; b++) p = p ^ obs_nodes[k*GRP_W+b];
                obs_q[k] = p;
            end
            for (int j = 0; j < NUM_SP; j++) obs_q[NUM_OP+j] = sp_src[j];
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && obs_q.size() == OBS_LEN) begin
            logic [NUM_CP-1:0] ecp;
            logic [NUM_SP-1:0] esp;
            for (int i = 0; i < NUM_CP; i++) ecp[i] = test_mode ? ctl_q[i] : cp_src[i];
            for (int j = 0; j < NUM_SP; j++) esp[j] = test_mode ? ctl_q[NUM_CP+j] : sp_src[j];
            chk("R4 obs_so", 32'(obs_so), 32'(obs_q[OBS_LEN-1]));
            chk(scan_en ? "R5 ctl_so" : "R6 ctl_so", 32'(ctl_so), 32'(ctl_q[CTL_LEN-1]));
            chk(test_mode ? "R7 cp_dst" : "R2 cp_dst", 32'(cp_dst), 32'(ecp));
            chk(test_mode ? "R7 sp_dst" : "R2 sp_dst", 32'(sp_dst), 32'(esp));
        end
    end

    task automatic drive_cycle(input logic se, input logic tm);
        @(negedge clk);
        #1;
        scan_en   = se;
        test_mode = tm;
    endtask

    // shift a control pattern so that control cell i ends up holding pat[i]
    task automatic load_ctl(input logic [CTL_LEN-1:0] pat);
        for (int i = CTL_LEN-1; i >= 0; i--) begin
            @(negedge clk);
            #1;
            scan_en = 1'b1;
            ctl_si  = pat[i];
            obs_si  = 1'($urandom);
        end
        @(negedge clk);
        #1;
        scan_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [CTL_LEN-1:0] pat;
        logic [OBS_LEN-1:0] exp_cap;

        #1;
        rst_n     = 1'b0;
        test_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 obs_so", 32'(obs_so), 0);
        chk("R1 ctl_so", 32'(ctl_so), 0);
        chk("R1 cp_dst", 32'(cp_dst), 0);
        chk("R1 sp_dst", 32'(sp_dst), 0);
        #1;
        rst_n     = 1'b0;
        cp_src    = '1;
        sp_src    = '1;
        @(negedge clk);
        chk("R1 cp_dst forced", 32'(cp_dst), 0);
        chk("R1 sp_dst forced", 32'(sp_dst), 0);
        #1;
        rst_n     = 1'b1;
        test_mode = 1'b0;

        // functional traffic: R2 with both scan_en values
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            #1;
            scan_en   = 1'($urandom);
            cp_src    = NUM_CP'($urandom);
            sp_src    = NUM_SP'($urandom);
            obs_nodes = (NUM_OP*GRP_W)'($urandom);
            obs_si    = 1'($urandom);
            ctl_si    = 1'($urandom);
        end
        drive_cycle(1'b0, 1'b0);

        for (int p = 0; p < 5; p++) begin
            case (p)
                0: pat = '1;
                1: pat = '0;
                2: pat = CTL_LEN'(5'b10110);
                3: pat = CTL_LEN'(5'b01001);
                default: pat = CTL_LEN'($urandom);
            endcase
            load_ctl(pat);

            // R6 hold across capture cycles
            repeat (3) begin
                @(negedge clk);
                #1;
                obs_nodes = (NUM_OP*GRP_W)'($urandom);
                ctl_si    = ~ctl_si;
            end
            @(negedge clk);
            chk("R6 ctl_so held", 32'(ctl_so), 32'(pat[CTL_LEN-1]));
            #1;
            test_mode = 1'b1;
            cp_src    = ~pat[NUM_CP-1:0];
            sp_src    = ~pat[CTL_LEN-1:NUM_CP];
            @(negedge clk);
            chk("R7 cp_dst pattern", 32'(cp_dst), 32'(pat[NUM_CP-1:0]));
            chk("R7 sp_dst pattern", 32'(sp_dst), 32'(pat[CTL_LEN-1:NUM_CP]));

            // capture one set of nodes
            #1;
            case (p)
                0: obs_nodes = '1;
                1: obs_nodes = 6'b010101;
                2: obs_nodes = 6'b100111;
                default: obs_nodes = (NUM_OP*GRP_W)'($urandom);
            endcase
            sp_src = NUM_SP'($urandom);
            for (int k = 0; k < NUM_OP; k++) begin
                int ones;
                ones = 0;
                for (int b = 0; b < GRP_W; b++) ones += int'(obs_nodes[k*GRP_W+b]);
                exp_cap[k] = (ones % 2) == 1;
            end
            for (int j = 0; j < NUM_SP; j++) exp_cap[NUM_OP+j] = sp_src[j];

            // unload: last cell appears first
            for (int i = 0; i < OBS_LEN; i++) begin
                int idx;
                @(negedge clk);
                idx = OBS_LEN - 1 - i;
                if (idx < NUM_OP)
                    chk("R3 R8 unload op", 32'(obs_so), 32'(exp_cap[idx]));
                else
                    chk("R3 R9 unload sp", 32'(obs_so), 32'(exp_cap[idx]));
                #1;
                scan_en   = 1'b1;
                obs_si    = 1'b0;
                obs_nodes = ~obs_nodes;
                sp_src    = ~sp_src;
            end
            @(negedge clk);
            // R4 the zero shifted in from obs_si reaches the output after a full pass
            chk("R4 obs_si fill", 32'(obs_so), 32'(exp_cap[OBS_LEN-1] & 1'b0));
            #1;
            scan_en   = 1'b0;
            test_mode = 1'b0;
        end

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule